// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The block collects interrupt requests from up to eight devices and stores each one in a pending register until it is serviced. It combines the pending bits with a per-device mask. While any pending, unmasked request exists, it holds its interrupt output high toward the processor.

The processor answers with two active-low acknowledge pulses. On the falling edge of the first pulse, the block picks the winning request among the pending, unmasked bits and retires that bit. During the second pulse it places an 8-bit vector on its data bus. The vector is the programmed base with its low three bits replaced by the winner's index.

A small register port lets software set the mask and the vector base. The port has a chip select, read and write strobes, and one address bit. The data bus has an output enable that is high only while the block drives the bus.

Top module: `prio_irq_ctl`

## Requirements
- R1: After reset, `irq_out` and `dout_en` are low, the mask reads 0xFF (all devices masked) and the base reads 0x00.
- R2: A request input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the input drops, until an acknowledge retires it.
- R3: `irq_out` is high exactly when some pending bit has a mask bit of 0. A masked pending bit is kept, and it raises `irq_out` once it is unmasked.
- R4: With `sel_n` and `wr_n` low at a clock edge, address 0 writes the mask (bit i masks request i) and address 1 writes the base. The base keeps only bits 7:3. With `sel_n` and `rd_n` low, address 0 reads the mask and address 1 reads the base with bits 2:0 zero.
- R5: At the falling edge of the first acknowledge pulse, the winner is the lowest-numbered request that is both pending and unmasked. Request 0 has the highest priority.
- R6: The vector is {base[7:3], winner index}. It is driven, with `dout_en` high, only while the second acknowledge pulse is low. `dout_en` stays low during and after the first pulse.
- R7: The first acknowledge clears only the winner's pending bit. Other pending bits stay set, and `irq_out` falls if no unmasked bit remains.
- R8: If nothing is pending and unmasked at the first acknowledge, the vector carries index 7 and no pending bit is cleared.
- R9: `dout_en` is low except during the second acknowledge pulse and during register reads. A write never drives the bus.
- R10: The mask is applied when the winner is chosen. A pending, masked request of higher priority is passed over, and it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Device request lines, index 0 highest priority |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_n | input | 1 | Active-low acknowledge pulses from the processor |
| sel_n | input | 1 | Active-low chip select for the register port |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 1 | Register select: 0 mask, 1 base |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or vector |
| dout_en | output | 1 | Bus drive enable (tri-state control) |

## Verification
A pending bit that is lost or kept by mistake shows up in the clock after the next acknowledge. It appears either as a vector with the wrong index or as `irq_out` staying high, or falling, when it should not. A wrong acknowledge phase shows up at once as `dout_en` rising during the first pulse, or as no vector during the second. A mask error appears in the first sample after the write: `irq_out` follows the mask against the pending set, and a masked bit that is later unmasked must raise the line again without a new request.

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl #(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_in,
  output logic            irq_out,
  input  logic            ack_n,
  input  logic            sel_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            dout_en
);
  localparam int IW = $clog2(NREQ);

  typedef enum logic [1:0] {ACK_IDLE, ACK_WAIT2, ACK_DRIVE} ack_t;

  logic [NREQ-1:0] pend_q, mask_q, live, clr;
  logic [7:0]      base_q;
  logic [IW-1:0]   win_idx, win_q;
  logic            ack_q, ack_fall, ack_first, ack_second, any_hit;
  logic            wr_hit, rd_hit, drive_vec;
  ack_t            phase_q;

  assign live       = pend_q & ~mask_q;
  assign any_hit    = |live;
  assign irq_out    = any_hit;
  assign ack_fall   = ack_q & ~ack_n;
  assign ack_first  = ack_fall && (phase_q == ACK_IDLE);
  assign ack_second = ack_fall && (phase_q == ACK_WAIT2);
  assign wr_hit     = !sel_n && !wr_n;
  assign rd_hit     = !sel_n && !rd_n;
  assign drive_vec  = (phase_q == ACK_DRIVE) && !ack_n;

  always_comb begin
    win_idx = IW'(NREQ - 1);
    for (int i = NREQ - 1; i >= 0; i--)
      if (live[i]) win_idx = IW'(i);
  end

  always_comb begin
    clr = '0;
    if (ack_first && any_hit) clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '1;
      base_q  <= '0;
      ack_q   <= 1'b1;
      phase_q <= ACK_IDLE;
      win_q   <= '0;
    end else begin
      ack_q  <= ack_n;
      pend_q <= (pend_q | req_in) & ~clr;
      if (wr_hit) begin
        if (addr) base_q <= {din[7:IW], {IW{1'b0}}};
        else      mask_q <= din[NREQ-1:0];
      end
      case (phase_q)
        ACK_IDLE:  if (ack_first) begin
                     phase_q <= ACK_WAIT2;
                     win_q   <= win_idx;
                   end
        ACK_WAIT2: if (ack_second) phase_q <= ACK_DRIVE;
        ACK_DRIVE: if (ack_n) phase_q <= ACK_IDLE;
        default:   phase_q <= ACK_IDLE;
      endcase
    end
  end

  always_comb begin
    dout = '0;
    if (drive_vec)   dout = {base_q[7:IW], win_q};
    else if (rd_hit) dout = addr ? base_q : 8'(mask_q);
  end

  assign dout_en = drive_vec | rd_hit;
endmodule

// File: rtl/prio_irq_ctl_chk.sv
module prio_irq_ctl_chk #(
  parameter int NREQ = 8,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_in,
  input logic            ack_n,
  input logic            sel_n,
  input logic            rd_n,
  input logic [7:0]      dout,
  input logic            dout_en,
  input logic [NREQ-1:0] pend,
  input logic [NREQ-1:0] mask,
  input logic [7:0]      base,
  input logic            ack1,
  input logic            hit,
  input logic [IW-1:0]   win
);
  logic [NREQ-1:0] above;
  assign above = (pend & ~mask) & ((NREQ'(1) << win) - NREQ'(1));

  // R9
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ack_n || (!sel_n && !rd_n)));

  // R6
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !ack_n && (sel_n || rd_n)) |-> dout[7:IW] == base[7:IW]);

  // R5
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1 && hit) |-> (above == '0) && pend[win] && !mask[win]);

  // R7
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1 && hit) |=> !pend[$past(win)]);

  // R2
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack1 |=> ((pend & $past(req_in | pend)) == $past(req_in | pend)));
endmodule

bind prio_irq_ctl prio_irq_ctl_chk #(.NREQ(NREQ), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_n(ack_n), .sel_n(sel_n),
  .rd_n(rd_n), .dout(dout), .dout_en(dout_en), .pend(pend_q), .mask(mask_q),
  .base(base_q), .ack1(ack_first), .hit(any_hit), .win(win_idx)
);

// File: tb/prio_irq_ctl_tb.sv
module prio_irq_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       ack_n = 1'b1, sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, irq_out;
  int         runs = 0, fails = 0;
  bit         done = 0;

  prio_irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .irq_out(irq_out), .ack_n(ack_n),
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    sel_n = 0; wr_n = 0; addr = a; din = d;
    #1 chk("R9 no drive on write", {7'd0, dout_en}, 8'd0);
    tick();
    sel_n = 1; wr_n = 1;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    sel_n = 0; rd_n = 0; addr = a;
    #1;
    chk("R9 drive on read", {7'd0, dout_en}, 8'd1);
    d = dout;
    #1 sel_n = 1; rd_n = 1;
  endtask

  task automatic pulse_req(logic [7:0] r);
    req_in = r; tick(); req_in = '0;
  endtask

  task automatic do_ack(string tag, logic [7:0] exp_vec);
    ack_n = 0; tick();
    chk({tag, " no drive first pulse"}, {7'd0, dout_en}, 8'd0);
    ack_n = 1; tick();
    ack_n = 0; tick();
    chk({tag, " enable second pulse"}, {7'd0, dout_en}, 8'd1);
    chk({tag, " vector"}, dout, exp_vec);
    ack_n = 1; tick();
    chk({tag, " released"}, {7'd0, dout_en}, 8'd0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq_out}, 8'd0);
    chk("R1 dout_en", {7'd0, dout_en}, 8'd0);
    rd_reg(0, v); chk("R1 mask", v, 8'hFF);
    rd_reg(1, v); chk("R1 base", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr_reg(0, 8'h5A); rd_reg(0, v); chk("R4 mask rw", v, 8'h5A);
    wr_reg(1, 8'hA7); rd_reg(1, v); chk("R4 base low bits", v, 8'hA0);
    wr_reg(1, 8'h40); wr_reg(0, 8'h00);
  endtask

  task automatic t_latch_single();
    pulse_req(8'h08);
    chk("R2 r3_ irq after pulse", {7'd0, irq_out}, 8'd1);
    tick(); tick();
    chk("R2 held", {7'd0, irq_out}, 8'd1);
    do_ack("R6", 8'h43);
    chk("R7 irq drops", {7'd0, irq_out}, 8'd0);
  endtask

  task automatic t_priority();
    pulse_req(8'h90);
    do_ack("R5 first", 8'h44);
    chk("R7 other kept", {7'd0, irq_out}, 8'd1);
    do_ack("R5 second", 8'h47);
    chk("R7 empty", {7'd0, irq_out}, 8'd0);
  endtask

  task automatic t_mask();
    wr_reg(0, 8'h01);
    pulse_req(8'h01);
    chk("R3 masked no irq", {7'd0, irq_out}, 8'd0);
    pulse_req(8'h20);
    chk("R3 unmasked irq", {7'd0, irq_out}, 8'd1);
    do_ack("R10 skip masked", 8'h45);
    chk("R10 masked left", {7'd0, irq_out}, 8'd0);
    wr_reg(0, 8'h00);
    chk("R3 unmask raises", {7'd0, irq_out}, 8'd1);
    do_ack("R10 later", 8'h40);
  endtask

  task automatic t_spurious();
    do_ack("R8 empty", 8'h47);
    chk("R8 irq low", {7'd0, irq_out}, 8'd0);
    wr_reg(0, 8'h02);
    pulse_req(8'h02);
    do_ack("R8 masked only", 8'h47);
    wr_reg(0, 8'h00);
    chk("R8 bit kept", {7'd0, irq_out}, 8'd1);
    do_ack("R8 then", 8'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_latch_single();
    t_priority();
    t_mask();
    t_spurious();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule